// File: doc/BRIEF.md
# EPP 1.7 Parallel Cycle Engine

This block connects a simple host register bus to an Enhanced Parallel Port peripheral. The host addresses five registers: a data register, a status register, a control register, and two EPP ports that are each backed by a peripheral strobe. The two EPP ports are the address port and the data port. A host read or write of an EPP port, made while the static `epp_mode` input is high, runs one handshake on the peripheral bus. The handshake is tied to the host strobe. The block drives the byte, or releases the bus, and asserts the matching peripheral strobe. It holds the host's ready line low while the peripheral stretches the cycle with its wait input. The peripheral strobe is released when the host ends its access.

Outside an EPP cycle the port behaves as a standard or bidirectional parallel port. The strobe, autofeed and init pins follow the control register, and bit 5 of the control register selects the bus direction. A watchdog of `TMO_CYCLES` clock cycles guards every EPP cycle. If the watchdog expires, the cycle is aborted at once and a sticky time-out flag is set. The host clears the flag by reading the status register. The host strobes and the wait input each pass through a two-stage synchroniser before the sequencer uses them.

Top module: `epp_cycle_engine`

## Requirements
- R1: After reset the control register and the data register are 0 and the time-out flag is 0. Both peripheral strobes are high, `host_rdy` is high, `spp_strobe_n` and `spp_autofd_n` are 1, `spp_init_n` is 0, `per_oe` is 1 and `per_write_n` is 0.
- R2: When no EPP cycle is running, `spp_strobe_n` equals the inverse of control bit 0, `spp_autofd_n` equals the inverse of control bit 1, and `spp_init_n` equals control bit 2. While an EPP cycle runs, `spp_strobe_n` and `spp_autofd_n` are held at 1.
- R3: The register select codes are 0 for data, 1 for status, 2 for control, 3 for EPP address and 4 for EPP data. `per_oe` is the inverse of control bit 5 and `per_write_n` equals control bit 5. A host write to the data register appears on `per_dout`. A host read of the data register returns `per_din` when control bit 5 is 1.
- R4: On an EPP write, the host byte is on `per_dout` with `per_oe` high for at least one clock before the strobe falls. Select 3 lowers `per_astb_n` and select 4 lowers `per_dstb_n`. The two strobes are never low together.
- R5: When the host write strobe is released, the active peripheral strobe returns high. The written byte stays on `per_dout` afterwards.
- R6: On an EPP read with control bit 5 set, `per_oe` is 0 and `per_write_n` is 1 while the strobe is low. After the cycle, a host read of select 3 or 4 returns the `per_din` byte that was sampled while `per_wait_n` was high.
- R7: During an EPP cycle, `host_rdy` is low while the synchronised `per_wait_n` is low, until the strobe phase ends. Otherwise `host_rdy` is high.
- R8: After `TMO_CYCLES` clocks in a cycle, the cycle aborts. Both strobes go high, `host_rdy` goes high, and the block returns to idle even when `per_wait_n` is still low. If the wait release and the expiry fall in the same clock, the expiry wins.
- R9: The time-out flag is status bit 0. It stays set until a host read of the status register ends, and that read clears it.
- R10: `irq_out` equals `per_intr` without inversion. Status bit 1 also reflects `per_intr`.
- R11: With `epp_mode` low, accesses to selects 3 and 4 start no cycle. The strobes stay high and `per_dout` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| epp_mode | input | 1 | Static enable for EPP cycles |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_sel | input | 3 | Register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rdy | output | 1 | Host ready, low stretches the access |
| per_dout | output | 8 | Peripheral bus drive value |
| per_din | input | 8 | Peripheral bus input value |
| per_oe | output | 1 | Peripheral bus output enable |
| per_write_n | output | 1 | Direction to peripheral, low for write |
| per_dstb_n | output | 1 | Data strobe, active low |
| per_astb_n | output | 1 | Address strobe, active low |
| per_wait_n | input | 1 | Peripheral wait, low extends the cycle |
| per_intr | input | 1 | Peripheral interrupt, active high |
| irq_out | output | 1 | Interrupt to host |
| spp_strobe_n | output | 1 | Standard mode strobe pin |
| spp_autofd_n | output | 1 | Standard mode autofeed pin |
| spp_init_n | output | 1 | Standard mode init pin |

## Verification
The watchdog expiry and the peripheral's release of the wait line can land on the same clock edge. On that edge one path aborts the cycle and sets the flag, while the other ends the cycle normally. The bench provokes this by holding the wait line low and then releasing both the wait line and the host strobe after a counted number of edges. The sweep runs from two edges before the limit to one edge past it. After each try the bench reads status bit 0 and compares it with its own prediction: the flag is expected to be set exactly when the release comes on or after the limit edge.

// File: rtl/epp_pkg.sv
package epp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_STROBE = 3'd1,
    ST_WAIT   = 3'd2,
    ST_HOLD   = 3'd3,
    ST_ABORT  = 3'd4
  } epp_state_e;

  localparam logic [2:0] SEL_DATA   = 3'd0;
  localparam logic [2:0] SEL_STATUS = 3'd1;
  localparam logic [2:0] SEL_CTRL   = 3'd2;
  localparam logic [2:0] SEL_EADDR  = 3'd3;
  localparam logic [2:0] SEL_EDATA  = 3'd4;

  localparam int CTRL_DIR_BIT = 5;

  function automatic logic is_epp_sel(input logic [2:0] sel);
    return (sel == SEL_EADDR) || (sel == SEL_EDATA);
  endfunction

  function automatic logic [7:0] status_byte(input logic intr, input logic tmo);
    return {6'b000000, intr, tmo};
  endfunction

  // {strobe_n, autofd_n, init_n} for the standard port when idle
  function automatic logic [2:0] spp_pins(input logic [7:0] ctrl, input logic busy);
    logic [2:0] p;
    p[2] = busy ? 1'b1 : ~ctrl[0];
    p[1] = busy ? 1'b1 : ~ctrl[1];
    p[0] = ctrl[2];
    return p;
  endfunction

  function automatic logic strobe_phase(input epp_state_e st);
    return (st == ST_WAIT) || (st == ST_HOLD);
  endfunction

  function automatic logic timed_phase(input epp_state_e st);
    return (st == ST_STROBE) || (st == ST_WAIT) || (st == ST_HOLD);
  endfunction

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/epp_watchdog.sv
module epp_watchdog #(
  parameter int TMO_CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic hit,
  output logic [$clog2(TMO_CYCLES+1)-1:0] count
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign hit   = run && (cnt_q == LAST);
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clear)
      cnt_q <= '0;
    else if (run && !hit)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/epp_regs.sv
module epp_regs
  import epp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] sel,
  input  logic [7:0] wdata,
  input  logic       epp_load,
  input  logic       tmo_set,
  input  logic       tmo_clr,
  input  logic       rd_cap,
  input  logic [7:0] din,
  input  logic       intr,
  output logic [7:0] ctrl,
  output logic [7:0] data,
  output logic       tmo,
  output logic [7:0] rdata
);
  logic [7:0] ctrl_q, data_q, rd_q;
  logic       tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
      tmo_q  <= 1'b0;
    end else begin
      if (reg_we && sel == SEL_CTRL) ctrl_q <= wdata;
      if ((reg_we && sel == SEL_DATA) || epp_load) data_q <= wdata;
      if (rd_cap) rd_q <= din;
      if (tmo_set)      tmo_q <= 1'b1;
      else if (tmo_clr) tmo_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DATA:   rdata = ctrl_q[CTRL_DIR_BIT] ? din : data_q;
      SEL_STATUS: rdata = status_byte(intr, tmo_q);
      SEL_CTRL:   rdata = ctrl_q;
      SEL_EADDR,
      SEL_EDATA:  rdata = rd_q;
      default:    rdata = 8'hFF;
    endcase
  end

  assign ctrl = ctrl_q;
  assign data = data_q;
  assign tmo  = tmo_q;
endmodule

// File: rtl/epp_fsm.sv
module epp_fsm
  import epp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_wr,
  input  logic       start_addr,
  input  logic       host_idle,
  input  logic       wait_ok,
  input  logic       tmo_hit,
  output epp_state_e state,
  output logic       cyc_write,
  output logic       cyc_addr,
  output logic       ev_abort,
  output logic       ev_done
);
  epp_state_e st_q, st_d;
  logic       wr_q, addr_q;

  always_comb begin
    st_d     = st_q;
    ev_abort = 1'b0;
    ev_done  = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (start) st_d = ST_STROBE;
      ST_STROBE: begin
        if (tmo_hit) begin st_d = ST_ABORT; ev_abort = 1'b1; end
        else st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (tmo_hit) begin st_d = ST_ABORT; ev_abort = 1'b1; end
        else if (host_idle) begin st_d = ST_IDLE; ev_done = wait_ok; end
        else if (wait_ok) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (tmo_hit) begin st_d = ST_ABORT; ev_abort = 1'b1; end
        else if (host_idle) begin st_d = ST_IDLE; ev_done = 1'b1; end
      end
      ST_ABORT:  st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wr_q   <= 1'b0;
      addr_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start) begin
        wr_q   <= start_wr;
        addr_q <= start_addr;
      end
    end
  end

  assign state     = st_q;
  assign cyc_write = wr_q;
  assign cyc_addr  = addr_q;
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
  import epp_pkg::*;
#(
  parameter int TMO_CYCLES = 2500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       epp_mode,
  input  logic       host_rd_n,
  input  logic       host_wr_n,
  input  logic [2:0] host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_rdy,
  output logic [7:0] per_dout,
  input  logic [7:0] per_din,
  output logic       per_oe,
  output logic       per_write_n,
  output logic       per_dstb_n,
  output logic       per_astb_n,
  input  logic       per_wait_n,
  input  logic       per_intr,
  output logic       irq_out,
  output logic       spp_strobe_n,
  output logic       spp_autofd_n,
  output logic       spp_init_n
);
  localparam int CW = $clog2(TMO_CYCLES + 1);

  logic [2:0] sync_in, sync_out;
  logic       rd_s, wr_s, wait_s;
  logic       rd_d, wr_d;
  logic       rd_fall, wr_fall, rd_rise;

  assign sync_in = {host_rd_n, host_wr_n, per_wait_n};

  epp_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_in), .q(sync_out)
  );
  assign {rd_s, wr_s, wait_s} = sync_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_d <= 1'b1;
      wr_d <= 1'b1;
    end else begin
      rd_d <= rd_s;
      wr_d <= wr_s;
    end
  end

  assign rd_fall = rd_d & ~rd_s;
  assign wr_fall = wr_d & ~wr_s;
  assign rd_rise = ~rd_d & rd_s;

  epp_state_e state;
  logic cyc_write, cyc_addr, ev_abort, ev_done;
  logic busy, epp_hit_sel, epp_start, tmo_hit, wd_run;
  logic [CW-1:0] wd_cnt;

  assign busy        = (state != ST_IDLE);
  assign epp_hit_sel = epp_mode && is_epp_sel(host_sel);
  assign epp_start   = (rd_fall | wr_fall) && epp_hit_sel && !busy;
  assign wd_run      = timed_phase(state);

  epp_watchdog #(.TMO_CYCLES(TMO_CYCLES)) u_wdog (
    .clk(clk), .rst_n(rst_n), .clear(epp_start), .run(wd_run),
    .hit(tmo_hit), .count(wd_cnt)
  );

  epp_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start(epp_start), .start_wr(wr_fall), .start_addr(host_sel == SEL_EADDR),
    .host_idle(rd_s & wr_s), .wait_ok(wait_s), .tmo_hit(tmo_hit),
    .state(state), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
    .ev_abort(ev_abort), .ev_done(ev_done)
  );

  logic [7:0] ctrl, data;
  logic       tmo_flag;
  logic       reg_we, epp_load, rd_cap, tmo_clr;

  assign reg_we   = wr_fall && !busy && !epp_hit_sel;
  assign epp_load = (epp_start && wr_fall) || (ev_done && cyc_write);
  assign rd_cap   = strobe_phase(state) && wait_s && !cyc_write;
  assign tmo_clr  = rd_rise && (host_sel == SEL_STATUS);

  epp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .sel(host_sel), .wdata(host_wdata),
    .epp_load(epp_load), .tmo_set(ev_abort), .tmo_clr(tmo_clr), .rd_cap(rd_cap),
    .din(per_din), .intr(per_intr), .ctrl(ctrl), .data(data), .tmo(tmo_flag),
    .rdata(host_rdata)
  );

  logic stb_on;
  assign stb_on     = strobe_phase(state);
  assign per_astb_n = !(stb_on && cyc_addr);
  assign per_dstb_n = !(stb_on && !cyc_addr);
  assign host_rdy   = !(((state == ST_STROBE) || (state == ST_WAIT)) && !wait_s);

  assign per_dout    = data;
  assign per_oe      = ~ctrl[CTRL_DIR_BIT];
  assign per_write_n = ctrl[CTRL_DIR_BIT];
  assign irq_out     = per_intr;
  assign {spp_strobe_n, spp_autofd_n, spp_init_n} = spp_pins(ctrl, busy);
endmodule

// File: rtl/epp_cycle_engine_chk.sv
module epp_cycle_engine_chk
  import epp_pkg::*;
#(
  parameter int TMO_CYCLES = 2500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       epp_mode,
  input logic       busy,
  input logic       cyc_write,
  input logic       ev_abort,
  input logic       wait_s,
  input logic       tmo_flag,
  input logic [$clog2(TMO_CYCLES+1)-1:0] wd_cnt,
  input logic       host_rdy,
  input logic [7:0] per_dout,
  input logic       per_oe,
  input logic       per_write_n,
  input logic       per_dstb_n,
  input logic       per_astb_n
);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!per_astb_n && !per_dstb_n));

  assert_write_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(per_astb_n) || $fell(per_dstb_n)) && cyc_write) |-> (per_oe && $stable(per_dout)));

  assert_read_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((!per_astb_n || !per_dstb_n) && !cyc_write) |-> (!per_oe && per_write_n));

  assert_rdy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rdy |-> (!wait_s && busy));

  assert_abort_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (per_astb_n && per_dstb_n && host_rdy && tmo_flag));

  assert_wdog_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_cnt < ($clog2(TMO_CYCLES+1))'(TMO_CYCLES));

  assert_mode_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!epp_mode && !busy) |=> !busy);
endmodule

bind epp_cycle_engine epp_cycle_engine_chk #(.TMO_CYCLES(TMO_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .epp_mode(epp_mode), .busy(busy), .cyc_write(cyc_write),
  .ev_abort(ev_abort), .wait_s(wait_s), .tmo_flag(tmo_flag), .wd_cnt(wd_cnt),
  .host_rdy(host_rdy), .per_dout(per_dout), .per_oe(per_oe), .per_write_n(per_write_n),
  .per_dstb_n(per_dstb_n), .per_astb_n(per_astb_n)
);

// File: tb/epp_cycle_engine_bench.sv
module epp_cycle_engine_bench;
  localparam int LIM = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic epp_mode = 1'b1;
  logic host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [2:0] host_sel = 3'd0;
  logic [7:0] host_wdata = 8'h00, host_rdata;
  logic host_rdy;
  logic [7:0] per_dout, per_din = 8'h00;
  logic per_oe, per_write_n, per_dstb_n, per_astb_n;
  logic per_wait_n = 1'b1, per_intr = 1'b0;
  logic irq_out, spp_strobe_n, spp_autofd_n, spp_init_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  epp_cycle_engine #(.TMO_CYCLES(LIM)) u_epp_cycle_engine (
    .clk(clk), .rst_n(rst_n), .epp_mode(epp_mode), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .host_sel(host_sel), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rdy(host_rdy), .per_dout(per_dout),
    .per_din(per_din), .per_oe(per_oe), .per_write_n(per_write_n),
    .per_dstb_n(per_dstb_n), .per_astb_n(per_astb_n), .per_wait_n(per_wait_n),
    .per_intr(per_intr), .irq_out(irq_out), .spp_strobe_n(spp_strobe_n),
    .spp_autofd_n(spp_autofd_n), .spp_init_n(spp_init_n)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [2:0] exp_spp(input logic [7:0] c);
    return {~c[0], ~c[1], c[2]};
  endfunction

  function automatic logic exp_flag(input int rel_edge);
    return rel_edge >= LIM;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_wdata = d; host_wr_n = 1'b0;
    idle(4);
    host_wr_n = 1'b1;
    idle(4);
  endtask

  task automatic reg_read(input logic [2:0] sel, output logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_rd_n = 1'b0;
    idle(4);
    d = host_rdata;
    host_rd_n = 1'b1;
    idle(4);
  endtask

  task automatic epp_write(input bit addr, input logic [7:0] d);
    logic [7:0] prev;
    bit seen;
    seen = 0;
    @(negedge clk);
    host_sel = addr ? 3'd3 : 3'd4; host_wdata = d; host_wr_n = 1'b0;
    prev = per_dout;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (!per_astb_n || !per_dstb_n) begin
        seen = 1;
        check("R4 setup byte", {prev, per_dout, 7'b0, per_oe}, {d, d, 8'h01});
        check("R4 strobe pick", {per_astb_n, per_dstb_n}, addr ? 2'b01 : 2'b10);
      end else prev = per_dout;
    end
    check("R4 strobe seen", seen, 1);
    host_wr_n = 1'b1;
    idle(5);
    check("R5 strobe release and byte kept", {per_astb_n, per_dstb_n, per_dout}, {2'b11, d});
  endtask

  task automatic epp_read(input bit addr, input logic [7:0] v);
    bit seen;
    seen = 0;
    @(negedge clk);
    host_sel = addr ? 3'd3 : 3'd4; per_din = v; host_rd_n = 1'b0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (!per_astb_n || !per_dstb_n) begin
        seen = 1;
        check("R6 read direction", {per_oe, per_write_n}, 2'b01);
      end
    end
    check("R6 strobe seen", seen, 1);
    host_rd_n = 1'b1;
    idle(5);
    per_din = ~v;
    check("R6 read byte", host_rdata, v);
  endtask

  // stalled cycle; release of wait and host strobe after rel posedges
  task automatic stall_cycle(input int rel);
    @(negedge clk);
    host_sel = 3'd4; host_wdata = 8'h5A; per_wait_n = 1'b0; host_wr_n = 1'b0;
    repeat (rel) @(posedge clk);
    @(negedge clk);
    per_wait_n = 1'b1; host_wr_n = 1'b1;
    idle(6);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rb, c, d;
    void'($urandom(32'd1234));
    idle(3);
    check("R1 reset outputs",
          {per_astb_n, per_dstb_n, host_rdy, spp_strobe_n, spp_autofd_n, spp_init_n, per_oe, per_write_n},
          8'b11111010);
    check("R1 reset data", per_dout, 8'h00);
    rst_n = 1'b1;
    idle(3);
    reg_read(3'd1, rb);
    check("R1 reset flag", rb[0], 0);

    // R2 / R3 random control and data patterns
    for (int i = 0; i < 12; i++) begin
      c = 8'($urandom) & 8'h2F;
      d = 8'($urandom);
      reg_write(3'd2, c);
      reg_write(3'd0, d);
      check("R2 idle pins", {spp_strobe_n, spp_autofd_n, spp_init_n}, exp_spp(c));
      check("R3 direction", {per_oe, per_write_n}, {~c[5], c[5]});
      check("R3 data reg", per_dout, d);
      per_din = 8'($urandom);
      reg_read(3'd0, rb);
      check("R3 data read", rb, c[5] ? per_din : d);
    end

    // R4/R5/R6 random EPP traffic
    for (int i = 0; i < 16; i++) begin
      bit a;
      a = 1'($urandom);
      d = 8'($urandom);
      if ($urandom % 2 == 0) begin
        reg_write(3'd2, 8'h04);
        epp_write(a, d);
      end else begin
        reg_write(3'd2, 8'h24);
        epp_read(a, d);
      end
    end

    // R7 wait extension; R2 pins held during cycle
    reg_write(3'd2, 8'h03);
    @(negedge clk);
    host_sel = 3'd4; host_wdata = 8'hC3; per_wait_n = 1'b0; host_wr_n = 1'b0;
    idle(8);
    check("R7 rdy low under wait", host_rdy, 0);
    check("R2 pins held in cycle", {spp_strobe_n, spp_autofd_n}, 2'b11);
    per_wait_n = 1'b1;
    idle(4);
    check("R7 rdy back high", host_rdy, 1);
    host_wr_n = 1'b1;
    idle(5);
    check("R2 pins return", {spp_strobe_n, spp_autofd_n}, 2'b00);
    reg_write(3'd2, 8'h04);

    // R8 timeout abort with wait held low
    @(negedge clk);
    host_sel = 3'd3; per_wait_n = 1'b0; host_wr_n = 1'b0;
    idle(LIM + 8);
    check("R8 abort releases", {per_astb_n, per_dstb_n, host_rdy}, 3'b111);
    host_wr_n = 1'b1; per_wait_n = 1'b1;
    idle(4);
    reg_read(3'd1, rb);
    check("R9 flag set", rb[0], 1);
    reg_read(3'd1, rb);
    check("R9 flag cleared by read", rb[0], 0);

    // R8 collision sweep around the limit
    for (int r = LIM - 2; r <= LIM + 1; r++) begin
      stall_cycle(r);
      reg_read(3'd1, rb);
      check("R8 expiry vs release", rb[0], exp_flag(r));
    end

    // R10 interrupt pass-through
    per_intr = 1'b1;
    idle(1);
    check("R10 irq high", irq_out, 1);
    reg_read(3'd1, rb);
    check("R10 status intr", rb[1], 1);
    per_intr = 1'b0;
    idle(1);
    check("R10 irq low", irq_out, 0);

    // R11 mode off: no cycle
    reg_write(3'd0, 8'h11);
    epp_mode = 1'b0;
    @(negedge clk);
    host_sel = 3'd4; host_wdata = 8'hEE; host_wr_n = 1'b0;
    idle(5);
    check("R11 no strobe", {per_astb_n, per_dstb_n}, 2'b11);
    host_wr_n = 1'b1;
    idle(5);
    check("R11 bus unchanged", per_dout, 8'h11);
    epp_mode = 1'b1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule